// File: doc/BRIEF.md
# Character Display Command Sequencer

This block feeds a parallel 8-bit character display from a fast system clock. An internal divider derives a slow step from the system clock. On every rising step the sequencer presents one transfer to the display: data byte, register-select level and status LED. An enable strobe is then pulsed in the low half of the step, while those lines are steady.

After reset, the first transfer is an entry-mode command. That command makes the cursor advance after each character, with no display shift. A bounded run of character writes follows. The block then sends a cursor-home command and goes back to a new run of writes, and it loops like this without end.

Every output is a flop on the system clock. The slow step is used only as a one-cycle qualifier and never as a clock, so no output can stay at the value of an earlier state.

Top module: `lcd_cmd_seq`

## Requirements
- R1: While the synchronous reset is high, and in the cycle after it, `lcd_data`, `lcd_rs`, `lcd_en` and `status_led` are all low. The sequence restarts at the entry-mode command with the character count at zero.
- R2: The internal step toggles once every `DIV_LIMIT` system cycles. After reset is released, `lcd_en` first reads high on the (2·`DIV_LIMIT`+1)-th cycle. After that, it rises once every 2·`DIV_LIMIT` cycles.
- R3: Each enable pulse is high for `DIV_LIMIT`−1 cycles. `lcd_data` and `lcd_rs` do not change while it is high, nor in the cycle after it falls.
- R4: The first strobed transfer after reset has `lcd_rs`=0, `lcd_data`=0x06 (cursor increments, no shift) and `status_led`=0.
- R5: The entry-mode transfer is followed by exactly `CHAR_COUNT` consecutive character writes. Each one has `lcd_rs`=1, `lcd_data`=0x5F and `status_led`=1.
- R6: After each run of character writes comes one cursor-home transfer, with `lcd_rs`=0, `lcd_data`=`HOME_CODE` (default 0x02) and `status_led`=1. It is followed by a new run of `CHAR_COUNT` writes, and this repeats.
- R7: Between two consecutive enable pulses, the data bus, register select and LED change at most once.
- R8: When reset is high in the same cycle that a step advance is pending, reset wins. The outputs go low and the next strobe is the entry-mode command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| lcd_data | output | 8 | Display data/command bus |
| lcd_rs | output | 1 | Register select: 1 for character data, 0 for command |
| lcd_en | output | 1 | Display enable strobe |
| status_led | output | 1 | High once character writing has begun |

## Verification
Reset and a step advance can fall in the same system cycle. Whichever one the sequencer honours decides whether the transfer latched in that cycle ever reaches the display. The bench provokes the collision in the middle of a character run. It raises reset on the falling edge right after an enable pulse ends, which is the cycle in which the advance qualifier is high. It then judges the result at the ports: all outputs must read low, and the first strobe after release must be the entry-mode command and must arrive at the same cycle distance as after a cold reset.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

   typedef enum logic [1:0] {
      ST_ENTRY = 2'd0,
      ST_DATA  = 2'd1,
      ST_HOME  = 2'd2
   } seq_state_e;

   function automatic int cnt_width(input int limit);
      return (limit > 1) ? $clog2(limit) : 1;
   endfunction

endpackage

// File: rtl/lcd_tick_div.sv
module lcd_tick_div #(
   parameter int DIV_LIMIT = 25000
) (
   input  logic clk,
   input  logic rst,
   output logic rise_tick,
   output logic fall_tick,
   output logic hold_end
);
   import lcd_seq_pkg::*;

   localparam int CNT_W = cnt_width(DIV_LIMIT);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_LIMIT - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             step_q;
   logic             wrap;

   generate
      if (DIV_LIMIT < 2) begin : g_bad_div
         $error("lcd_tick_div: DIV_LIMIT must be at least 2");
      end
   endgenerate

   assign wrap     = (cnt_q == LAST);
   assign hold_end = wrap & ~step_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q     <= '0;
         step_q    <= 1'b0;
         rise_tick <= 1'b0;
         fall_tick <= 1'b0;
      end else begin
         rise_tick <= wrap & ~step_q;
         fall_tick <= wrap & step_q;
         if (wrap) begin
            cnt_q  <= '0;
            step_q <= ~step_q;
         end else begin
            cnt_q  <= cnt_q + 1'b1;
         end
      end
   end

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= LAST);                                                   // R2

   AST_STEP_TOGGLE: assert property (@(posedge clk) disable iff (rst)
      wrap |=> (step_q != $past(step_q)));                              // R2

   AST_TICKS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
      !(rise_tick && fall_tick));                                       // R2

endmodule

// File: rtl/lcd_seq_fsm.sv
module lcd_seq_fsm #(
   parameter int              DATA_W     = 8,
   parameter int              CHAR_COUNT = 16,
   parameter logic [DATA_W-1:0] ENTRY_CODE = 8'h06,
   parameter logic [DATA_W-1:0] DATA_CODE  = 8'h5F,
   parameter logic [DATA_W-1:0] HOME_CODE  = 8'h02
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              advance,
   output logic [DATA_W-1:0] bus_q,
   output logic              rs_q,
   output logic              led_q
);
   import lcd_seq_pkg::*;

   seq_state_e state_q;
   logic       last_char;

   generate
      if (CHAR_COUNT < 1) begin : g_bad_count
         $error("lcd_seq_fsm: CHAR_COUNT must be at least 1");
      end

      if (CHAR_COUNT == 1) begin : g_single
         assign last_char = 1'b1;
      end else begin : g_counter
         localparam int CHR_W = cnt_width(CHAR_COUNT);
         localparam logic [CHR_W-1:0] CHR_LAST = CHR_W'(CHAR_COUNT - 1);
         logic [CHR_W-1:0] chr_q;

         assign last_char = (chr_q == CHR_LAST);

         always_ff @(posedge clk) begin
            if (rst) begin
               chr_q <= '0;
            end else if (advance && state_q == ST_DATA) begin
               chr_q <= last_char ? '0 : chr_q + 1'b1;
            end
         end

         AST_CHAR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
            chr_q <= CHR_LAST);                                         // R5

         AST_CHAR_ONLY_IN_DATA: assert property (@(posedge clk) disable iff (rst)
            (state_q != ST_DATA) |-> (chr_q == '0));                    // R6
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_ENTRY;
         bus_q   <= '0;
         rs_q    <= 1'b0;
         led_q   <= 1'b0;
      end else if (advance) begin
         case (state_q)
            ST_ENTRY: begin
               bus_q   <= ENTRY_CODE;
               rs_q    <= 1'b0;
               led_q   <= 1'b0;
               state_q <= ST_DATA;
            end
            ST_DATA: begin
               bus_q   <= DATA_CODE;
               rs_q    <= 1'b1;
               led_q   <= 1'b1;
               state_q <= last_char ? ST_HOME : ST_DATA;
            end
            ST_HOME: begin
               bus_q   <= HOME_CODE;
               rs_q    <= 1'b0;
               led_q   <= 1'b1;
               state_q <= ST_DATA;
            end
            default: begin
               bus_q   <= '0;
               rs_q    <= 1'b0;
               led_q   <= 1'b0;
               state_q <= ST_ENTRY;
            end
         endcase
      end
   end

   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (bus_q == '0 && !rs_q && !led_q));                        // R1

   AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
      !advance |=> ($stable(bus_q) && $stable(rs_q) && $stable(led_q))); // R7

   AST_DATA_FIELDS: assert property (@(posedge clk) disable iff (rst)
      rs_q |-> (bus_q == DATA_CODE && led_q));                          // R5

   AST_ENTRY_LED_OFF: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_ENTRY) |-> !led_q);                                // R4

endmodule

// File: rtl/lcd_strobe.sv
module lcd_strobe (
   input  logic clk,
   input  logic rst,
   input  logic open_tick,
   input  logic close_now,
   input  logic rise_tick,
   output logic en_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         en_q <= 1'b0;
      end else if (open_tick) begin
         en_q <= 1'b1;
      end else if (close_now) begin
         en_q <= 1'b0;
      end
   end

   AST_EN_LOW_AT_ADVANCE: assert property (@(posedge clk) disable iff (rst)
      rise_tick |-> !en_q);                                             // R3

   AST_EN_RESET: assert property (@(posedge clk)
      rst |=> !en_q);                                                   // R1

endmodule

// File: rtl/lcd_cmd_seq.sv
module lcd_cmd_seq #(
   parameter int         DIV_LIMIT  = 25000,
   parameter int         CHAR_COUNT = 16,
   parameter logic [7:0] HOME_CODE  = 8'h02
) (
   input  logic       clk,
   input  logic       rst,
   output logic [7:0] lcd_data,
   output logic       lcd_rs,
   output logic       lcd_en,
   output logic       status_led
);

   logic rise_tick;
   logic fall_tick;
   logic hold_end;

   lcd_tick_div #(
      .DIV_LIMIT (DIV_LIMIT)
   ) u_div (
      .clk       (clk),
      .rst       (rst),
      .rise_tick (rise_tick),
      .fall_tick (fall_tick),
      .hold_end  (hold_end)
   );

   lcd_seq_fsm #(
      .DATA_W     (8),
      .CHAR_COUNT (CHAR_COUNT),
      .ENTRY_CODE (8'h06),
      .DATA_CODE  (8'h5F),
      .HOME_CODE  (HOME_CODE)
   ) u_fsm (
      .clk     (clk),
      .rst     (rst),
      .advance (rise_tick),
      .bus_q   (lcd_data),
      .rs_q    (lcd_rs),
      .led_q   (status_led)
   );

   lcd_strobe u_strobe (
      .clk       (clk),
      .rst       (rst),
      .open_tick (fall_tick),
      .close_now (hold_end),
      .rise_tick (rise_tick),
      .en_q      (lcd_en)
   );

endmodule

// File: tb/test_lcd_cmd_seq.sv
`timescale 1ns/1ps
module test_lcd_cmd_seq;

   localparam int D = 4;
   localparam int N = 3;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] lcd_data;
   logic       lcd_rs;
   logic       lcd_en;
   logic       status_led;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int last_rise = -1;

   always #4 clk = ~clk;
   always @(posedge clk) cyc++;

   lcd_cmd_seq #(
      .DIV_LIMIT  (D),
      .CHAR_COUNT (N),
      .HOME_CODE  (8'h02)
   ) i_lcd_cmd_seq (
      .clk        (clk),
      .rst        (rst),
      .lcd_data   (lcd_data),
      .lcd_rs     (lcd_rs),
      .lcd_en     (lcd_en),
      .status_led (status_led)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // Wait for the next enable pulse; checks R2 period, R3 width/stability, R7.
   task automatic wait_strobe(output logic [7:0] d, output logic r, output logic l,
                              output int gap);
      int         changes = 0;
      int         width;
      logic [9:0] prev = {lcd_data, lcd_rs, status_led};
      gap = 0;
      do begin
         @(negedge clk);
         gap++;
         if ({lcd_data, lcd_rs, status_led} != prev) begin
            changes++;
            prev = {lcd_data, lcd_rs, status_led};
         end
      end while (!lcd_en);
      check(changes <= 1, "R7 output changes between strobes", changes, 1);
      if (last_rise >= 0)
         check(cyc - last_rise == 2 * D, "R2 strobe period", cyc - last_rise, 2 * D);
      last_rise = cyc;
      d = lcd_data; r = lcd_rs; l = status_led;
      width = 1;
      forever begin
         @(negedge clk);
         if (!lcd_en) break;
         width++;
         check(lcd_data == d && lcd_rs == r, "R3 bus stable while enabled",
               {lcd_data, lcd_rs}, {d, r});
      end
      check(width == D - 1, "R3 enable width", width, D - 1);
      check(lcd_data == d && lcd_rs == r, "R3 bus held after enable falls",
            {lcd_data, lcd_rs}, {d, r});
   endtask

   task automatic expect_xfer(input string req, input logic [7:0] ed, input logic er,
                              input logic el);
      logic [7:0] d; logic r; logic l; int gap;
      wait_strobe(d, r, l, gap);
      check(d == ed && r == er && l == el, req, {d, r, l}, {ed, er, el});
   endtask

   task automatic release_and_first();
      int gap;
      logic [7:0] d; logic r; logic l;
      @(negedge clk);
      rst = 1'b0;
      last_rise = -1;
      wait_strobe(d, r, l, gap);
      check(gap == 2 * D + 1, "R2 first strobe delay after reset", gap, 2 * D + 1);
      check(d == 8'h06 && r == 1'b0 && l == 1'b0, "R4 entry-mode transfer",
            {d, r, l}, {8'h06, 1'b0, 1'b0});
   endtask

   task automatic test_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      check(lcd_data == 8'h00 && !lcd_rs && !lcd_en && !status_led, "R1 outputs low in reset",
            {lcd_data, lcd_rs, lcd_en, status_led}, 0);
   endtask

   task automatic test_loop();
      release_and_first();
      for (int rep = 0; rep < 2; rep++) begin
         for (int i = 0; i < N; i++)
            expect_xfer("R5 character write", 8'h5F, 1'b1, 1'b1);
         expect_xfer("R6 cursor-home transfer", 8'h02, 1'b0, 1'b1);
      end
      expect_xfer("R6 writes resume after home", 8'h5F, 1'b1, 1'b1);
   endtask

   task automatic test_reset_collision();
      // Enable just fell: the advance qualifier is high in this cycle.
      rst = 1'b1;
      @(negedge clk);
      check(lcd_data == 8'h00 && !lcd_rs && !lcd_en && !status_led, "R8 reset wins over advance",
            {lcd_data, lcd_rs, lcd_en, status_led}, 0);
      @(negedge clk);
      check(lcd_data == 8'h00 && !status_led, "R1 outputs low after reset",
            {lcd_data, status_led}, 0);
      release_and_first();
      for (int i = 0; i < N; i++)
         expect_xfer("R8 full character run after reset", 8'h5F, 1'b1, 1'b1);
      expect_xfer("R8 home after restarted run", 8'h02, 1'b0, 1'b1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      test_reset();
      test_loop();
      expect_xfer("R5 first write of a run", 8'h5F, 1'b1, 1'b1);
      test_reset_collision();
      test_reset();
      test_loop();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule